// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

A bank of four physical event counters behind a simple word-addressed register bus. Each physical counter runs either as a single 32-bit counter or as two independent 16-bit halves, so software sees eight logical counters. Logical counter `p` (0 to 3) is the whole counter, or its upper half when split. Logical counter `p+4` is the lower half of physical counter `p` and exists only while that counter is split.

A write to a counter does not touch the live count. It lands in a holding latch and is marked pending. Pending values are committed by any write to the global control register that has the run bit set, including a rewrite while the bank is already running. Counting happens only while the run bit is set. Clearing it freezes every count and keeps any pending latch contents.

A logical counter that wraps from all-ones to zero sets a sticky status bit. An interrupt line is raised while any status bit is set and its mask bit is also set. Reading the status register returns the pending bits and clears them. Writing that register loads the mask.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every register reads zero, all counters and latches are zero, every physical counter is in 32-bit mode, and `irq` is low.
- R2: Word addresses are: 0 global control, 1 status/mask, 8+n the value of logical counter n, 16+n the control word of logical counter n (n = 0..7). Register data sits in bus bits 63:32. Reads return zero in bits 31:0, and writes ignore bits 31:0.
- R3: A counter write changes only a holding latch. Pending halves load into the live counter on the next control write with bit 0 set, whether the bank was stopped or already running. In that cycle the loaded halves do not count.
- R4: Control bit 0 is the run bit. Counters advance only while it is set. Clearing it freezes all values, and pending latch contents survive until the next commit.
- R5: In 32-bit mode, logical counter p advances by one on each cycle with `event_in[p]` high. Logical counters 4..7 of an unsplit counter read zero, and writes to them are ignored.
- R6: Control bit 8+p splits physical counter p. Its upper 16 bits are logical p, clocked by `event_in[p]`. Its lower 16 bits are logical p+4, clocked by `event_in[p+4]`. No carry passes from the lower half to the upper half.
- R7: A logical counter wrapping from all-ones to zero sets status bit n, where n is its logical index. The bit stays set until it is cleared.
- R8: Writing the status/mask address loads the interrupt mask from data bits 7:0. `irq` is high exactly when some status bit and its mask bit are both set, so writing zero forces `irq` low.
- R9: Reading the status/mask address returns the status bits and clears them in the same access. A wrap in that same cycle is still recorded.
- R10: Each logical counter has a 32-bit control word that is stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for clear-on-read) |
| bus_wdata | input | 64 | Write data, register in bits 63:32 |
| bus_rdata | output | 64 | Read data, register in bits 63:32 |
| event_in | input | 8 | Event pulses, one per logical counter |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending flag or a misplaced latch half shows up only when a commit happens. The symptom is a counter read that comes back stale or with a half swapped, one cycle after the control write. A carry leaking across a split boundary, or a count taken while stopped, corrupts the readback of a neighbouring logical counter on the very next access. A lost or duplicated status bit shows on `irq` one cycle after the wrap or the mask write, and in the value returned by the next status read. Randomised event streams over mixed split patterns compare every logical counter with running totals kept in the bench.

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int NPHYS = 4,
  localparam int NLOG = 2 * NPHYS,
  localparam int AW = $clog2(3 * NLOG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [63:0]     bus_wdata,
  output logic [63:0]     bus_rdata,
  input  logic [NLOG-1:0] event_in,
  output logic            irq
);
  localparam int CNT_BASE  = NLOG;
  localparam int LCTL_BASE = 2 * NLOG;
  localparam int SPLIT_LSB = 8;

  logic [31:0]                ctrl_q;
  logic [NLOG-1:0]            irq_stat_q, irq_mask_q;
  logic [NPHYS-1:0][31:0]     phys_q, latch_q, phys_nxt;
  logic [NPHYS-1:0]           pend_hi_q, pend_lo_q, ovf_hi, ovf_lo;
  logic [NLOG-1:0][31:0]      lctl_q, log_val;
  logic [31:0]                rd32;

  wire [31:0]      wval   = bus_wdata[63:32];
  wire             run    = ctrl_q[0];
  wire [NPHYS-1:0] split  = ctrl_q[SPLIT_LSB +: NPHYS];
  wire             commit = bus_wr && bus_addr == AW'(0) && wval[0];
  wire             st_rd  = bus_rd && bus_addr == AW'(1);

  for (genvar p = 0; p < NPHYS; p++) begin : g_ctr
    logic [32:0] wide;
    logic [16:0] hi16, lo16;
    logic        ld_hi, ld_lo;
    assign wide  = {1'b0, phys_q[p]} + 33'(run & event_in[p]);
    assign hi16  = {1'b0, phys_q[p][31:16]} + 17'(run & event_in[p]);
    assign lo16  = {1'b0, phys_q[p][15:0]} + 17'(run & event_in[p+NPHYS]);
    assign ld_hi = commit & pend_hi_q[p];
    assign ld_lo = commit & pend_lo_q[p];
    assign phys_nxt[p][31:16] = ld_hi ? latch_q[p][31:16] :
                                (split[p] ? hi16[15:0] : wide[31:16]);
    assign phys_nxt[p][15:0]  = ld_lo ? latch_q[p][15:0] :
                                (split[p] ? lo16[15:0] : wide[15:0]);
    assign ovf_hi[p] = split[p] ? (hi16[16] & ~ld_hi) : (wide[32] & ~ld_hi & ~ld_lo);
    assign ovf_lo[p] = split[p] & lo16[16] & ~ld_lo;
    assign log_val[p]       = split[p] ? {16'b0, phys_q[p][31:16]} : phys_q[p];
    assign log_val[p+NPHYS] = split[p] ? {16'b0, phys_q[p][15:0]} : 32'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      irq_stat_q <= '0;
      irq_mask_q <= '0;
      phys_q     <= '0;
      latch_q    <= '0;
      pend_hi_q  <= '0;
      pend_lo_q  <= '0;
      lctl_q     <= '0;
    end else begin
      phys_q     <= phys_nxt;
      irq_stat_q <= (st_rd ? '0 : irq_stat_q) | {ovf_lo, ovf_hi};
      if (bus_wr && bus_addr == AW'(0)) ctrl_q <= wval;
      if (bus_wr && bus_addr == AW'(1)) irq_mask_q <= wval[NLOG-1:0];
      for (int p = 0; p < NPHYS; p++) begin
        if (bus_wr && bus_addr == AW'(CNT_BASE + p)) begin
          pend_hi_q[p] <= 1'b1;
          if (split[p]) latch_q[p][31:16] <= wval[15:0];
          else begin
            latch_q[p]   <= wval;
            pend_lo_q[p] <= 1'b1;
          end
        end else if (bus_wr && bus_addr == AW'(CNT_BASE + NPHYS + p) && split[p]) begin
          latch_q[p][15:0] <= wval[15:0];
          pend_lo_q[p]     <= 1'b1;
        end
        if (commit) begin
          pend_hi_q[p] <= 1'b0;
          pend_lo_q[p] <= 1'b0;
        end
      end
      for (int i = 0; i < NLOG; i++)
        if (bus_wr && bus_addr == AW'(LCTL_BASE + i)) lctl_q[i] <= wval;
    end
  end

  always_comb begin
    rd32 = '0;
    if (bus_addr == AW'(0)) rd32 = ctrl_q;
    if (bus_addr == AW'(1)) rd32 = 32'(irq_stat_q);
    for (int i = 0; i < NLOG; i++) begin
      if (bus_addr == AW'(CNT_BASE + i))  rd32 = log_val[i];
      if (bus_addr == AW'(LCTL_BASE + i)) rd32 = lctl_q[i];
    end
  end

  assign bus_rdata = {rd32, 32'b0};
  assign irq       = |(irq_stat_q & irq_mask_q);
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int NPHYS = 4,
  localparam int NLOG = 2 * NPHYS,
  localparam int AW = $clog2(3 * NLOG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [63:0]            bus_wdata,
  input logic [NLOG-1:0]        event_in,
  input logic                   irq,
  input logic [31:0]            ctrl_q,
  input logic [NPHYS-1:0][31:0] phys_q,
  input logic [NLOG-1:0]        irq_stat_q,
  input logic [NLOG-1:0]        irq_mask_q
);
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !bus_wr) |=> $stable(phys_q));

  assert_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[8] && !bus_wr && !event_in[0]) |=> $stable(phys_q[0][31:16]));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == AW'(1)) |=> ((irq_stat_q & $past(irq_stat_q)) == $past(irq_stat_q)));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1)) |=> irq_mask_q == $past(bus_wdata[32 +: NLOG]));

  assert_unmasked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_q == '0) |-> !irq);

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(1) && event_in == '0) |=> irq_stat_q == '0);
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NPHYS(NPHYS)) chk (.*);

// File: tb/perf_ctr_bank_test.sv
module perf_ctr_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, irq;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  event_in = '0;
  int          errors = 0, checks = 0;

  logic [31:0] exp_full [4];
  logic [15:0] exp_hi [4], exp_lo [4];
  logic [3:0]  rsplit;

  perf_ctr_bank uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] v, logic [31:0] low = 32'h0);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = {v, low};
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v, output logic [31:0] low);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata[63:32]; low = bus_rdata[31:0];
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rdchk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] v, l;
    rd(a, v, l);
    chk(req, v, exp);
  endtask

  task automatic pulse(logic [7:0] ev, int n);
    @(negedge clk); event_in = ev;
    repeat (n) @(negedge clk);
    event_in = '0;
  endtask

  function automatic logic [31:0] exp_log(int i);
    int p = i % 4;
    if (i < 4) return rsplit[p] ? {16'b0, exp_hi[p]} : exp_full[p];
    return rsplit[p] ? {16'b0, exp_lo[p]} : 32'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, l;
    int unsigned seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rdchk("R1 ctrl", 5'd0, 0);
    rdchk("R1 status", 5'd1, 0);
    rdchk("R1 cnt0", 5'd8, 0);
    rdchk("R1 lctl7", 5'd23, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 / R10 bus placement and control words
    wr(5'd16, 32'hCAFE0001, 32'hFFFFFFFF);
    rd(5'd16, v, l);
    chk("R10 lctl0", v, 32'hCAFE0001);
    chk("R2 low half", l, 0);
    rdchk("R10 lctl1 untouched", 5'd17, 0);

    // R3 latch while stopped
    wr(5'd8, 32'h100);
    rdchk("R3 not yet live", 5'd8, 0);
    wr(5'd0, 1);
    rdchk("R3 committed", 5'd8, 32'h100);
    // R3 commit while running
    wr(5'd9, 5);
    rdchk("R3 pending while running", 5'd9, 0);
    wr(5'd0, 1);
    rdchk("R3 recommit", 5'd9, 5);

    // R5 32-bit counting
    pulse(8'h01, 10);
    rdchk("R5 count", 5'd8, 32'h10A);

    // R4 freeze and keep pending
    wr(5'd0, 0);
    wr(5'd10, 7);
    pulse(8'hFF, 5);
    rdchk("R4 frozen", 5'd8, 32'h10A);
    rdchk("R4 latch not live", 5'd10, 0);
    wr(5'd0, 1);
    rdchk("R4 pending kept", 5'd10, 7);

    // R7 / R8 / R9 overflow and interrupt
    wr(5'd11, 32'hFFFFFFFF);
    wr(5'd0, 1);
    rdchk("R3 cnt3 loaded", 5'd11, 32'hFFFFFFFF);
    pulse(8'h08, 1);
    rdchk("R7 wrap to zero", 5'd11, 0);
    chk("R8 masked irq", {31'b0, irq}, 0);
    wr(5'd1, 8);
    chk("R8 irq raised", {31'b0, irq}, 1);
    wr(5'd1, 0);
    chk("R8 zero mask", {31'b0, irq}, 0);
    wr(5'd1, 8);
    rdchk("R7 status bit3", 5'd1, 32'h08);
    chk("R9 irq after clear", {31'b0, irq}, 0);
    rdchk("R9 cleared", 5'd1, 0);

    // R6 split mode
    wr(5'd0, 32'h100);
    wr(5'd8, 32'h1234);
    wr(5'd12, 32'hFFFF);
    wr(5'd0, 32'h101);
    rdchk("R6 upper half", 5'd8, 32'h1234);
    rdchk("R6 lower half", 5'd12, 32'hFFFF);
    pulse(8'h10, 1);
    rdchk("R6 lower wrap", 5'd12, 0);
    rdchk("R6 no carry", 5'd8, 32'h1234);
    rdchk("R7 status bit4", 5'd1, 32'h10);
    pulse(8'h01, 3);
    rdchk("R6 upper counts", 5'd8, 32'h1237);
    rdchk("R6 lower still", 5'd12, 0);

    // R5 logical 5 absent in 32-bit mode
    rdchk("R5 absent reads zero", 5'd13, 0);
    wr(5'd13, 32'h77);
    wr(5'd0, 32'h101);
    rdchk("R5 write ignored", 5'd9, 5);

    // Random event streams over a random split pattern
    for (int round = 0; round < 4; round++) begin
      rsplit = 4'($urandom);
      wr(5'd0, 32'(rsplit) << 8);
      for (int i = 0; i < 8; i++) wr(5'(8 + i), 0);
      wr(5'd0, (32'(rsplit) << 8) | 1);
      for (int p = 0; p < 4; p++) begin
        exp_full[p] = 0; exp_hi[p] = 0; exp_lo[p] = 0;
      end
      for (int c = 0; c < 300; c++) begin
        logic [7:0] ev;
        ev = 8'($urandom);
        @(negedge clk); event_in = ev;
        for (int p = 0; p < 4; p++) begin
          if (rsplit[p]) begin
            exp_hi[p] += 16'(ev[p]);
            exp_lo[p] += 16'(ev[p+4]);
          end else exp_full[p] += 32'(ev[p]);
        end
      end
      @(negedge clk); event_in = '0;
      wr(5'd0, 32'(rsplit) << 8);
      for (int i = 0; i < 8; i++)
        rdchk(rsplit[i % 4] ? "R6 random split" : "R5 random full", 5'(8 + i), exp_log(i));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule